// File: doc/BRIEF.md
# Source-Synchronous Inter-Core Word Link

This block joins two cores that run on separate, unrelated clocks. The sending core hands 16-bit words to the link with a valid/ready handshake. The link then carries them on the sender's own clock, with a valid strobe. An optional chain of register stages covers long routes. At the far end the words are written into a dual-clock buffer, and the receiving core drains that buffer on its own clock. The path is fixed in advance, so words carry no routing header.

Flow control runs backwards over a single request line. The buffer raises the line when it has enough free entries to absorb every word that could already be on its way, and it computes this from its own write pointer and a synchronised copy of the read pointer. The request passes through the same number of stages as the data, on the same forwarded clock. Adding stages therefore changes only the free-space threshold, never the protocol. The sender's clock may stop outright while its core is idle. Nothing is lost or repeated when it does.

Top module: `xlink_top`

## Requirements
- R1: While rst_ni is low, rx_valid_o is low and no word is delivered.
- R2: Every word accepted at the sending side is delivered exactly once, in acceptance order, whether the sender clock is faster or slower than the receiver clock.
- R3: A word is never written into the receive buffer while it has no free entry, so an unread word is never overwritten.
- R4: A word is accepted on each rising src_clk_i edge where tx_valid_i and tx_ready_o are both high. After reset is released with an empty buffer, tx_ready_o is high within STAGES+2 src_clk_i edges.
- R5: With the receiver not draining, the sender is stopped after at least DEPTH-2*STAGES-3 and at most DEPTH-2 accepted words, and tx_ready_o stays low. tx_ready_o is never high while the buffer has no free entry.
- R6: While src_clk_i is halted, words already written stay readable. No further word appears once those are drained. When the clock resumes, the stream continues with no loss or duplication.
- R7: While rx_valid_o is high and rx_ready_i is low, rx_valid_o stays high and rx_data_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Sender core clock, forwarded along the link; may stop |
| dst_clk_i | input | 1 | Receiver core clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both sides |
| tx_data_i | input | WORD_W | Word offered by the sender |
| tx_valid_i | input | 1 | Sender has a word |
| tx_ready_o | output | 1 | Returned request: a word may transfer this edge |
| rx_data_o | output | WORD_W | Oldest unread word |
| rx_valid_o | output | 1 | Receive buffer holds a word |
| rx_ready_i | input | 1 | Receiver takes the word on the next dst_clk_i edge |

## Verification
The hardest state to reach from the ports is a sender clock that stops while words are still inside the forward stages and the pointer synchronisers. The receiver must then drain only what was written, and must get the rest once the clock resumes. The bench gates the sender clock only while it is low, at random points in a counting stream with the receiver always ready. It checks that the delivered count stays frozen late in each halt and that the sequence is unbroken afterwards. The free-space threshold is reached by stalling the receiver while the sender keeps offering words. The accepted count is then checked against the round-trip bound, and the stalled output is checked to hold still.

// File: rtl/xlink_pkg.sv
`timescale 1ns/1ps
package xlink_pkg;
  localparam int REQ_MARGIN = 2;

  // free entries needed to keep request high: forward + return in-flight words plus margin
  function automatic int req_level(input int stages);
    return 2 * stages + 2 + REQ_MARGIN;
  endfunction
endpackage

// File: rtl/xlink_sync.sv
`timescale 1ns/1ps
module xlink_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/xlink_pipe.sv
`timescale 1ns/1ps
module xlink_pipe #(
  parameter int W = 1,
  parameter int N = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  if (N == 0) begin : g_wire
    assign d_o = d_i;
  end else begin : g_regs
    logic [W-1:0] q [N];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < N; i++) q[i] <= '0;
      end else begin
        q[0] <= d_i;
        for (int i = 1; i < N; i++) q[i] <= q[i-1];
      end
    end
    assign d_o = q[N-1];
  end
endmodule

// File: rtl/xlink_fifo.sv
`timescale 1ns/1ps
module xlink_fifo #(
  parameter int W       = 16,
  parameter int DEPTH   = 16,
  parameter int REQ_MIN = 6,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic          wr_clk_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  output logic          req_o,
  output logic [PW-1:0] free_o,
  output logic [W-1:0]  rd_data_o,
  output logic          rd_valid_o,
  input  logic          rd_pop_i
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] rgray_w, wgray_r, used_w, wbin_nx, rbin_nx;
  logic          pop;

  // write side, forwarded clock
  assign wbin_nx = wbin_q + PW'(1);
  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_en_i) begin
      wbin_q  <= wbin_nx;
      wgray_q <= to_gray(wbin_nx);
    end
  end

  always_ff @(posedge wr_clk_i) begin
    if (wr_en_i) mem[wbin_q[AW-1:0]] <= wr_data_i;
  end

  xlink_sync #(.W(PW)) u_rsync (
    .clk_i (wr_clk_i),
    .rst_ni(rst_ni),
    .d_i   (rgray_q),
    .q_o   (rgray_w)
  );

  assign used_w = wbin_q - to_bin(rgray_w);
  assign free_o = PW'(DEPTH) - used_w;
  assign req_o  = free_o >= PW'(REQ_MIN);

  // read side, destination clock
  xlink_sync #(.W(PW)) u_wsync (
    .clk_i (rd_clk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray_q),
    .q_o   (wgray_r)
  );

  assign rd_valid_o = rgray_q != wgray_r;
  assign rd_data_o  = mem[rbin_q[AW-1:0]];
  assign pop        = rd_pop_i & rd_valid_o;
  assign rbin_nx    = rbin_q + PW'(1);

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (pop) begin
      rbin_q  <= rbin_nx;
      rgray_q <= to_gray(rbin_nx);
    end
  end
endmodule

// File: rtl/xlink_top.sv
`timescale 1ns/1ps
module xlink_top #(
  parameter int WORD_W = 16,
  parameter int STAGES = 2,
  parameter int DEPTH  = 16
) (
  input  logic              src_clk_i,
  input  logic              dst_clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i
);
  localparam int REQ_MIN = xlink_pkg::req_level(STAGES);
  localparam int FREE_W  = $clog2(DEPTH) + 1;

  logic              ln_v_q;
  logic [WORD_W-1:0] ln_d_q;
  logic              fifo_wr_en;
  logic [WORD_W-1:0] fifo_wr_data;
  logic              fifo_req;
  logic [FREE_W-1:0] fifo_free;
  logic              take;

  assign take = tx_valid_i & tx_ready_o;

  // sender launch register on the forwarded clock
  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ln_v_q <= 1'b0;
      ln_d_q <= '0;
    end else begin
      ln_v_q <= take;
      if (take) ln_d_q <= tx_data_i;
    end
  end

  xlink_pipe #(.W(WORD_W + 1), .N(STAGES)) u_fwd (
    .clk_i (src_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ln_v_q, ln_d_q}),
    .d_o   ({fifo_wr_en, fifo_wr_data})
  );

  xlink_pipe #(.W(1), .N(STAGES)) u_ret (
    .clk_i (src_clk_i),
    .rst_ni(rst_ni),
    .d_i   (fifo_req),
    .d_o   (tx_ready_o)
  );

  xlink_fifo #(.W(WORD_W), .DEPTH(DEPTH), .REQ_MIN(REQ_MIN)) u_fifo (
    .wr_clk_i  (src_clk_i),
    .rd_clk_i  (dst_clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (fifo_wr_en),
    .wr_data_i (fifo_wr_data),
    .req_o     (fifo_req),
    .free_o    (fifo_free),
    .rd_data_o (rx_data_o),
    .rd_valid_o(rx_valid_o),
    .rd_pop_i  (rx_ready_i)
  );
endmodule

// File: rtl/xlink_chk.sv
`timescale 1ns/1ps
module xlink_chk #(
  parameter int WORD_W = 16,
  parameter int FREE_W = 5
) (
  input logic              src_clk_i,
  input logic              dst_clk_i,
  input logic              rst_ni,
  input logic              wr_en,
  input logic [FREE_W-1:0] free,
  input logic              tx_ready_o,
  input logic              rx_valid_o,
  input logic              rx_ready_i,
  input logic [WORD_W-1:0] rx_data_o
);
  always @(posedge dst_clk_i) begin
    if (!rst_ni) a_r1_idle_in_reset: assert (!rx_valid_o);
  end

  a_r3_no_overflow: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    wr_en |-> (free != '0));

  a_r5_full_blocks_sender: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    (free == '0) |-> !tx_ready_o);

  a_r7_hold_while_stalled: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));
endmodule

bind xlink_top xlink_chk #(.WORD_W(WORD_W), .FREE_W(FREE_W)) u_chk (
  .src_clk_i (src_clk_i),
  .dst_clk_i (dst_clk_i),
  .rst_ni    (rst_ni),
  .wr_en     (fifo_wr_en),
  .free      (fifo_free),
  .tx_ready_o(tx_ready_o),
  .rx_valid_o(rx_valid_o),
  .rx_ready_i(rx_ready_i),
  .rx_data_o (rx_data_o)
);

// File: tb/sim_xlink_top.sv
`timescale 1ns/1ps
module sim_xlink_top;
  localparam int W = 16;
  localparam int S = 2;
  localparam int D = 16;

  logic         src_clk = 1'b0, dst_clk = 1'b0, rst_n = 1'b0, src_run = 1'b1;
  real          src_half = 6.5;
  logic [W-1:0] tx_data = '0;
  logic         tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0;
  logic [W-1:0] rx_data;

  int n_chk = 0, n_err = 0;
  int tx_total = 0, rx_total = 0, rx_mode = 0;
  logic [W-1:0] next_tx = '0, exp_rx = '0;

  xlink_top #(.WORD_W(W), .STAGES(S), .DEPTH(D)) u0 (
    .src_clk_i(src_clk), .dst_clk_i(dst_clk), .rst_ni(rst_n),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready)
  );

  always #10 dst_clk = ~dst_clk;
  // sender clock halts only in its low phase
  always begin
    #(src_half);
    if (src_run || src_clk) src_clk = ~src_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // receiver: ready set for the coming edge, then pop checked (R2)
  always @(negedge dst_clk) begin
    if (!rst_n) rx_ready = 1'b0;
    else begin
      case (rx_mode)
        0: rx_ready = 1'b0;
        1: rx_ready = 1'b1;
        default: rx_ready = ($urandom % 3) != 0;
      endcase
      if (rx_ready && rx_valid) begin
        check(rx_data === exp_rx, "R2 order", int'(rx_data), int'(exp_rx));
        exp_rx++;
        rx_total++;
      end
    end
  end

  task automatic send_words(input int n, input int max_cyc, output int sent);
    bit acc;
    sent = 0;
    for (int c = 0; c < max_cyc && sent < n; c++) begin
      @(negedge src_clk);
      tx_valid = 1'b1;
      tx_data  = next_tx;
      acc      = tx_ready;
      @(posedge src_clk);
      if (acc) begin
        sent++;
        tx_total++;
        next_tx++;
      end
    end
    @(negedge src_clk);
    tx_valid = 1'b0;
  endtask

  task automatic drain_check(input string req);
    repeat (300) @(posedge dst_clk);
    #1;
    check(rx_total == tx_total, req, rx_total, tx_total);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge dst_clk);
    check(rx_valid == 1'b0, "R1 valid in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    repeat (S + 2) @(posedge src_clk);
    @(negedge src_clk);
    check(tx_ready == 1'b1, "R4 ready after reset", int'(tx_ready), 1);
  endtask

  task automatic t_stream_fast();
    int sent;
    rx_mode = 1; src_half = 6.5;
    send_words(60, 3000, sent);
    check(sent == 60, "R4 all accepted", sent, 60);
    drain_check("R2 fast sender");
  endtask

  task automatic t_stream_slow();
    int sent;
    rx_mode = 2; src_half = 23.3;
    send_words(40, 3000, sent);
    drain_check("R2 slow sender random drain");
  endtask

  task automatic t_backpressure();
    int sent;
    logic [W-1:0] held;
    src_half = 7.0; rx_mode = 0;
    repeat (4) @(posedge dst_clk);
    send_words(100, 80, sent);
    check(sent >= D - 2 * S - 3 && sent <= D - 2, "R5 accepted bound", sent, D - 2);
    @(negedge src_clk);
    check(tx_ready == 1'b0, "R5 sender stopped", int'(tx_ready), 0);
    @(negedge dst_clk);
    check(rx_valid == 1'b1, "R7 valid held", int'(rx_valid), 1);
    check(rx_data === exp_rx, "R7 head word", int'(rx_data), int'(exp_rx));
    held = rx_data;
    repeat (10) @(negedge dst_clk);
    check(rx_valid == 1'b1 && rx_data === held, "R7 stable", int'(rx_data), int'(held));
    rx_mode = 1;
    send_words(30, 2000, sent);
    drain_check("R2 after backpressure");
  endtask

  task automatic t_halt();
    int sent, r0;
    rx_mode = 1; src_half = 5.0;
    fork
      send_words(50, 4000, sent);
      begin
        repeat (4) begin
          #(137 + $urandom % 200);
          src_run = 1'b0;
          #400;
          r0 = rx_total;
          #(100 + $urandom % 300);
          check(rx_total == r0, "R6 no word while halted", rx_total, r0);
          src_run = 1'b1;
        end
      end
    join
    check(sent == 50, "R6 all accepted", sent, 50);
    drain_check("R6 stream after halts");
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_stream_fast();
    t_stream_slow();
    t_backpressure();
    t_halt();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule